// File: doc/BRIEF.md
# Status Block FIFO Loader

This block holds one outgoing status packet that a host composes through a small register port, and hands it to a transmit engine as a stream of 32-bit quadlets once the host asks for it. The host sets a packet size, opens the buffer with one of two enable bits, writes quadlets one after another to a single data address, and sets a notify bit. When the stored length matches the programmed size, the block checks the destination offset carried in the header. If the offset is aligned, the block streams the packet out under a valid/ready handshake.

The packet layout is as follows. Quadlet 0 carries the upper 16 offset bits in [31:16] and the byte length in [15:0]. Quadlet 1 carries the lower 32 offset bits. Quadlet 2 carries an associate flag in bit 31 and the agent number in its low bits. The remaining quadlets are payload, which the block passes through untouched. A misaligned offset aborts the packet and raises a sticky error. Writes the block cannot take are dropped and raise a sticky ignored flag.

Top module: `sbf_loader`

## Requirements
- R1: After reset, tx_valid, notify_pend, err_misalign and ign_flag are 0, and fill_lvl is 0.
- R2: A write to address 1 (SIZE) sets the packet length to twice the written value, counted in quadlets. Values above DEPTH/2 are clamped to DEPTH/2. SIZE writes made while notify is pending are ignored.
- R3: A write to address 2 (DATA) stores one quadlet and raises fill_lvl by one, provided CTRL bit 0 or CTRL bit 1 is set and the buffer is below the packet length.
- R4: A DATA write that is not stored leaves fill_lvl unchanged and sets ign_flag. This covers writes with both enables clear, writes beyond the packet length, and writes made during streaming. A CTRL write with bit 3 set clears ign_flag and err_misalign.
- R5: A CTRL write (address 0) with bit 2 set makes notify pending. Once fill_lvl equals the packet length, tx_valid rises on the following cycle. Until then nothing is sent.
- R6: Quadlets leave in write order. While tx_valid is high and tx_ready is low, tx_data stays stable. tx_last marks the final quadlet.
- R7: After the last quadlet is accepted, notify_pend is 0 and fill_lvl is 0.
- R8: If bits [1:0] of quadlet 1 are not both zero at launch, err_misalign is set and nothing is sent. notify is cleared and the buffer is emptied.
- R9: While streaming, agent_sel_vld is 1 exactly when quadlet 2 was stored with bit 31 equal to 0. agent_num then shows bits [AGENT_W-1:0] of quadlet 2.
- R10: With a packet length of 0, a notify clears on the next cycle without any transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| host_we | input | 1 | Host register write strobe |
| host_addr | input | 2 | Register select: 0 CTRL, 1 SIZE, 2 DATA |
| host_wdata | input | 32 | Host write data |
| tx_valid | output | 1 | Quadlet available to the transmitter |
| tx_ready | input | 1 | Transmitter accepts the quadlet |
| tx_data | output | 32 | Outgoing quadlet |
| tx_last | output | 1 | Final quadlet of the packet |
| agent_sel_vld | output | 1 | Packet selects the agent given in agent_num |
| agent_num | output | AGENT_W | Agent number from quadlet 2 |
| notify_pend | output | 1 | Notify pending |
| fill_lvl | output | CNT_W | Quadlets stored |
| err_misalign | output | 1 | Sticky misaligned-offset error |
| ign_flag | output | 1 | Sticky dropped-write flag |

## Verification
The bench builds the block with DEPTH set to 8, so the clamp of an oversized SIZE value to DEPTH/2 can be reached with a handful of writes. A full eight-quadlet packet then also fills the storage completely, which makes the write-past-end drop and a stream that ends at the last storage slot both reachable. AGENT_W stays at 16, so the agent number is read straight out of the low half of quadlet 2.

// File: rtl/sbf_pkg.sv
package sbf_pkg;
    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_SIZE = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    localparam int CTL_EN_A   = 0;
    localparam int CTL_EN_B   = 1;
    localparam int CTL_NOTIFY = 2;
    localparam int CTL_CLR    = 3;

    localparam int HDR_OFFLO_IDX = 1;
    localparam int HDR_AGENT_IDX = 2;
    localparam int HDR_ASSOC_BIT = 31;

    typedef enum logic {ST_IDLE, ST_SEND} sbf_state_e;
endpackage

// File: rtl/sbf_regs.sv
module sbf_regs
    import sbf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_we,
    input  logic [1:0]       host_addr,
    input  logic [31:0]      host_wdata,
    input  logic [CNT_W-1:0] fill,
    input  logic             sending,
    input  logic             notify_clr,
    input  logic             err_set,
    output logic             wr_accept,
    output logic             notify,
    output logic [CNT_W-1:0] pkt_len,
    output logic             ign_flag,
    output logic             err_flag
);
    localparam logic [31:0] HALF = 32'(DEPTH / 2);

    typedef struct packed {
        logic             en_a;
        logic             en_b;
        logic             notify;
        logic             ign;
        logic             err;
        logic [CNT_W-1:0] len;
    } regs_t;

    regs_t       r_d, r_q;
    logic        data_wr;
    logic [31:0] lim;

    always_comb begin
        r_d       = r_q;
        data_wr   = host_we && (host_addr == ADDR_DATA);
        wr_accept = data_wr && (r_q.en_a || r_q.en_b) && (fill < r_q.len) && !sending;
        lim       = (host_wdata > HALF) ? HALF : host_wdata;

        if (data_wr && !wr_accept) begin
            r_d.ign = 1'b1;
        end
        if (host_we && host_addr == ADDR_CTRL) begin
            r_d.en_a = host_wdata[CTL_EN_A];
            r_d.en_b = host_wdata[CTL_EN_B];
            if (host_wdata[CTL_NOTIFY]) begin
                r_d.notify = 1'b1;
            end
            if (host_wdata[CTL_CLR]) begin
                r_d.ign = 1'b0;
                r_d.err = 1'b0;
            end
        end
        if (host_we && host_addr == ADDR_SIZE && !r_q.notify) begin
            r_d.len = CNT_W'(lim << 1);
        end
        if (notify_clr) begin
            r_d.notify = 1'b0;
        end
        if (err_set) begin
            r_d.err = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign notify   = r_q.notify;
    assign pkt_len  = r_q.len;
    assign ign_flag = r_q.ign;
    assign err_flag = r_q.err;

    AST_IGN_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == ADDR_DATA && !r_q.en_a && !r_q.en_b) |=> ign_flag); // R4

    AST_SIZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_addr == ADDR_SIZE && notify) |=> $stable(pkt_len)); // R2
endmodule

// File: rtl/sbf_store.sv
module sbf_store #(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1),
    parameter int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_accept,
    input  logic [31:0]      wdata,
    input  logic             flush,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [31:0]      rd_data,
    output logic [CNT_W-1:0] fill
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t         s_d, s_q;
    logic [31:0] mem [DEPTH];

    always_comb begin
        s_d = s_q;
        if (flush) begin
            s_d.cnt = '0;
        end else if (wr_accept) begin
            s_d.cnt = s_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_accept) begin
            mem[s_q.cnt[IDX_W-1:0]] <= wdata;
        end
    end

    assign rd_data = mem[rd_idx];
    assign fill    = s_q.cnt;

    AST_FILL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_accept && !flush) |=> fill == CNT_W'($past(fill) + 1'b1)); // R3
endmodule

// File: rtl/sbf_hdr.sv
module sbf_hdr
    import sbf_pkg::*;
#(
    parameter int CNT_W   = 5,
    parameter int AGENT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_accept,
    input  logic [CNT_W-1:0]   fill,
    input  logic [1:0]         off_lo_bits,
    input  logic               assoc_bit,
    input  logic [AGENT_W-1:0] agent_in,
    input  logic               flush,
    output logic               misal,
    output logic               assoc_n,
    output logic [AGENT_W-1:0] agent
);
    typedef struct packed {
        logic               misal;
        logic               assoc_n;
        logic [AGENT_W-1:0] agent;
    } hdr_t;

    hdr_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (flush) begin
            h_d.misal   = 1'b0;
            h_d.assoc_n = 1'b1;
            h_d.agent   = '0;
        end else if (wr_accept) begin
            if (fill == CNT_W'(HDR_OFFLO_IDX)) begin
                h_d.misal = |off_lo_bits;
            end
            if (fill == CNT_W'(HDR_AGENT_IDX)) begin
                h_d.assoc_n = assoc_bit;
                h_d.agent   = agent_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '{misal: 1'b0, assoc_n: 1'b1, agent: '0};
        end else begin
            h_q <= h_d;
        end
    end

    assign misal   = h_q.misal;
    assign assoc_n = h_q.assoc_n;
    assign agent   = h_q.agent;
endmodule

// File: rtl/sbf_launch.sv
module sbf_launch
    import sbf_pkg::*;
#(
    parameter int CNT_W = 5,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             notify,
    input  logic [CNT_W-1:0] fill,
    input  logic [CNT_W-1:0] pkt_len,
    input  logic             misal,
    input  logic [31:0]      rd_data,
    input  logic             tx_ready,
    output logic             tx_valid,
    output logic [31:0]      tx_data,
    output logic             tx_last,
    output logic [IDX_W-1:0] rd_idx,
    output logic             notify_clr,
    output logic             flush,
    output logic             err_set,
    output logic             sending
);
    typedef struct packed {
        sbf_state_e       state;
        logic [CNT_W-1:0] idx;
    } ln_t;

    ln_t l_d, l_q;

    always_comb begin
        l_d        = l_q;
        tx_valid   = 1'b0;
        tx_last    = 1'b0;
        notify_clr = 1'b0;
        flush      = 1'b0;
        err_set    = 1'b0;
        case (l_q.state)
            ST_IDLE: begin
                if (notify && fill == pkt_len) begin
                    if (pkt_len == '0) begin
                        notify_clr = 1'b1;
                    end else if (misal) begin
                        err_set    = 1'b1;
                        flush      = 1'b1;
                        notify_clr = 1'b1;
                    end else begin
                        l_d.state = ST_SEND;
                        l_d.idx   = '0;
                    end
                end
            end
            ST_SEND: begin
                tx_valid = 1'b1;
                tx_last  = (l_q.idx == pkt_len - CNT_W'(1));
                if (tx_ready) begin
                    if (tx_last) begin
                        l_d.state  = ST_IDLE;
                        l_d.idx    = '0;
                        flush      = 1'b1;
                        notify_clr = 1'b1;
                    end else begin
                        l_d.idx = l_q.idx + CNT_W'(1);
                    end
                end
            end
            default: l_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q <= '{state: ST_IDLE, idx: '0};
        end else begin
            l_q <= l_d;
        end
    end

    assign tx_data = rd_data;
    assign rd_idx  = l_q.idx[IDX_W-1:0];
    assign sending = (l_q.state == ST_SEND);

    AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data))); // R6
endmodule

// File: rtl/sbf_loader.sv
module sbf_loader #(
    parameter int DEPTH   = 16,
    parameter int AGENT_W = 16,
    parameter int CNT_W   = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               host_we,
    input  logic [1:0]         host_addr,
    input  logic [31:0]        host_wdata,
    output logic               tx_valid,
    input  logic               tx_ready,
    output logic [31:0]        tx_data,
    output logic               tx_last,
    output logic               agent_sel_vld,
    output logic [AGENT_W-1:0] agent_num,
    output logic               notify_pend,
    output logic [CNT_W-1:0]   fill_lvl,
    output logic               err_misalign,
    output logic               ign_flag
);
    localparam int IDX_W = $clog2(DEPTH);

    logic             wr_accept, notify, sending, notify_clr, flush, err_set;
    logic             misal, assoc_n;
    logic [CNT_W-1:0] pkt_len, fill;
    logic [IDX_W-1:0] rd_idx;
    logic [31:0]      rd_data;

    sbf_regs #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .fill(fill), .sending(sending), .notify_clr(notify_clr), .err_set(err_set),
        .wr_accept(wr_accept), .notify(notify), .pkt_len(pkt_len),
        .ign_flag(ign_flag), .err_flag(err_misalign)
    );

    sbf_store #(.DEPTH(DEPTH), .CNT_W(CNT_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_accept(wr_accept), .wdata(host_wdata), .flush(flush),
        .rd_idx(rd_idx), .rd_data(rd_data), .fill(fill)
    );

    sbf_hdr #(.CNT_W(CNT_W), .AGENT_W(AGENT_W)) u_hdr (
        .clk(clk), .rst_n(rst_n),
        .wr_accept(wr_accept), .fill(fill),
        .off_lo_bits(host_wdata[1:0]), .assoc_bit(host_wdata[31]),
        .agent_in(host_wdata[AGENT_W-1:0]), .flush(flush),
        .misal(misal), .assoc_n(assoc_n), .agent(agent_num)
    );

    sbf_launch #(.CNT_W(CNT_W), .IDX_W(IDX_W)) u_launch (
        .clk(clk), .rst_n(rst_n),
        .notify(notify), .fill(fill), .pkt_len(pkt_len), .misal(misal),
        .rd_data(rd_data), .tx_ready(tx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_last(tx_last),
        .rd_idx(rd_idx), .notify_clr(notify_clr), .flush(flush),
        .err_set(err_set), .sending(sending)
    );

    assign agent_sel_vld = sending && !assoc_n;
    assign notify_pend   = notify;
    assign fill_lvl      = fill;

    AST_ERR_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_misalign) |-> !tx_valid); // R8

    AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready && tx_last) |=> (!notify_pend && fill_lvl == '0)); // R7
endmodule

// File: tb/sim_sbf_loader.sv
module sim_sbf_loader;
    localparam int DEPTH   = 8;
    localparam int AGENT_W = 16;
    localparam int CNT_W   = $clog2(DEPTH + 1);
    localparam int NV      = 10;

    // {addr[38:37], data[36:5], exp fill[4:1], exp ign[0]}
    localparam logic [38:0] VEC [NV] = '{
        {2'd0, 32'h0000_0000, 4'd0, 1'b0},
        {2'd1, 32'h0000_0002, 4'd0, 1'b0},
        {2'd2, 32'hDEAD_0000, 4'd0, 1'b1},
        {2'd0, 32'h0000_0008, 4'd0, 1'b0},
        {2'd0, 32'h0000_0001, 4'd0, 1'b0},
        {2'd2, 32'h1234_0010, 4'd1, 1'b0},
        {2'd2, 32'h0000_1000, 4'd2, 1'b0},
        {2'd2, 32'h0000_0005, 4'd3, 1'b0},
        {2'd2, 32'hCAFE_0001, 4'd4, 1'b0},
        {2'd2, 32'hBAD0_BAD0, 4'd4, 1'b1}
    };

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               host_we = 1'b0;
    logic [1:0]         host_addr = '0;
    logic [31:0]        host_wdata = '0;
    logic               tx_ready = 1'b0;
    logic               tx_valid, tx_last, agent_sel_vld, notify_pend, err_misalign, ign_flag;
    logic [31:0]        tx_data;
    logic [AGENT_W-1:0] agent_num;
    logic [CNT_W-1:0]   fill_lvl;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;
    logic [31:0] exp_q [DEPTH];

    always #10 clk = ~clk;

    sbf_loader #(.DEPTH(DEPTH), .AGENT_W(AGENT_W)) u0 (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .tx_data(tx_data), .tx_last(tx_last), .agent_sel_vld(agent_sel_vld),
        .agent_num(agent_num), .notify_pend(notify_pend), .fill_lvl(fill_lvl),
        .err_misalign(err_misalign), .ign_flag(ign_flag)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        host_we    = 1'b1;
        host_addr  = a;
        host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic stream(input int n);
        for (int i = 0; i < n; i++) begin
            chk("R6 valid", {31'd0, tx_valid}, 32'd1);
            chk("R6 data", tx_data, exp_q[i]);
            chk("R6 last", {31'd0, tx_last}, {31'd0, (i == n - 1)});
            @(negedge clk);
        end
        chk("R7 valid drop", {31'd0, tx_valid}, 32'd0);
        chk("R7 notify clear", {31'd0, notify_pend}, 32'd0);
        chk("R7 fill empty", {28'd0, fill_lvl}, 32'd0);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 tx_valid", {31'd0, tx_valid}, 32'd0);
        chk("R1 notify", {31'd0, notify_pend}, 32'd0);
        chk("R1 fill", {28'd0, fill_lvl}, 32'd0);
        chk("R1 flags", {30'd0, err_misalign, ign_flag}, 32'd0);

        // Table walk: R3 fill tracking, R4 dropped writes
        for (int v = 0; v < NV; v++) begin
            wr(VEC[v][38:37], VEC[v][36:5]);
            chk("R3 fill", {28'd0, fill_lvl}, {28'd0, VEC[v][4:1]});
            chk("R4 ignored", {31'd0, ign_flag}, {31'd0, VEC[v][0]});
            exp_q[v % DEPTH] = VEC[v][36:5];
        end
        exp_q[0] = 32'h1234_0010; exp_q[1] = 32'h0000_1000;
        exp_q[2] = 32'h0000_0005; exp_q[3] = 32'hCAFE_0001;

        // R5 launch with backpressure, R6 hold, R9 agent
        wr(2'd0, 32'h0000_0005);
        chk("R5 no valid yet", {31'd0, tx_valid}, 32'd0);
        @(negedge clk);
        chk("R5 valid", {31'd0, tx_valid}, 32'd1);
        chk("R6 first", tx_data, exp_q[0]);
        chk("R9 agent sel", {31'd0, agent_sel_vld}, 32'd1);
        chk("R9 agent num", {16'd0, agent_num}, 32'd5);
        @(negedge clk);
        chk("R6 held", tx_data, exp_q[0]);
        chk("R6 held valid", {31'd0, tx_valid}, 32'd1);
        tx_ready = 1'b1;
        stream(4);

        // R8 misaligned offset, enable B only, flags cleared first (R4)
        wr(2'd0, 32'h0000_000A);
        chk("R4 clear", {30'd0, err_misalign, ign_flag}, 32'd0);
        wr(2'd1, 32'h0000_0001);
        wr(2'd2, 32'h5555_0008);
        wr(2'd2, 32'h0000_1002);
        chk("R3 en_b fill", {28'd0, fill_lvl}, 32'd2);
        wr(2'd0, 32'h0000_0006);
        chk("R8 no valid", {31'd0, tx_valid}, 32'd0);
        @(negedge clk);
        chk("R8 err", {31'd0, err_misalign}, 32'd1);
        chk("R8 no valid", {31'd0, tx_valid}, 32'd0);
        chk("R8 notify", {31'd0, notify_pend}, 32'd0);
        chk("R8 flush", {28'd0, fill_lvl}, 32'd0);

        // R5 notify before packet complete; R2 size write ignored while pending
        wr(2'd1, 32'h0000_0001);
        wr(2'd0, 32'h0000_0006);
        @(negedge clk);
        chk("R5 waits", {31'd0, tx_valid}, 32'd0);
        chk("R5 pending", {31'd0, notify_pend}, 32'd1);
        wr(2'd1, 32'h0000_0003);
        exp_q[0] = 32'h1111_0008; exp_q[1] = 32'h2222_0004;
        wr(2'd2, exp_q[0]);
        wr(2'd2, exp_q[1]);
        chk("R5 one cycle later", {31'd0, tx_valid}, 32'd0);
        @(negedge clk);
        chk("R9 no agent", {31'd0, agent_sel_vld}, 32'd0);
        stream(2);

        // R2 clamp: size 15 becomes DEPTH quadlets
        wr(2'd1, 32'h0000_000F);
        for (int i = 0; i < DEPTH; i++) begin
            exp_q[i] = 32'h100 + 32'(i * 4);
            wr(2'd2, exp_q[i]);
        end
        chk("R2 clamp fill", {28'd0, fill_lvl}, 32'(DEPTH));
        chk("R4 past end clean", {31'd0, ign_flag}, 32'd0);
        wr(2'd2, 32'hFFFF_FFFF);
        chk("R4 past end", {31'd0, ign_flag}, 32'd1);
        chk("R4 fill kept", {28'd0, fill_lvl}, 32'(DEPTH));
        wr(2'd0, 32'h0000_0006);
        @(negedge clk);
        stream(DEPTH);

        // R10 zero length
        wr(2'd1, 32'h0000_0000);
        wr(2'd0, 32'h0000_0006);
        chk("R10 set", {31'd0, notify_pend}, 32'd1);
        @(negedge clk);
        chk("R10 cleared", {31'd0, notify_pend}, 32'd0);
        chk("R10 no valid", {31'd0, tx_valid}, 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule